// File: doc/BRIEF.md
# Serial Device Access Pacing Sequencer

This block sits between a client that wants to talk to a serial slave device and the SPI host engine that moves the bits. The slave needs a minimum quiet time between accesses and may doze off when left idle. The sequencer holds each client request back until it is safe to start. It then either releases the request directly or first wakes the device with a chip-select pulse that carries no clock. Only after that does it tell the engine to start. The grant stays with the client until the engine reports completion.

The quiet time after a completed transaction is measured in ticks of a slow timebase, usually a millisecond. Without a usable ready interrupt the sequencer waits a fixed short gap. A rising edge on the ready interrupt ends the wait at once. While the interrupt line is present but unproven, the sequencer counts its pre-transaction checks. If an interrupt is seen by one of them, the gap turns into a long timeout ceiling. If none is seen after the allowed number of checks, it stops trying and keeps the short gap. A sticky warning flags a proven interrupt that failed to show up before the ceiling. Separately, the device is woken when enough ticks have passed since the previous pre-transaction check, and always after reset or a resume.

States: IDLE (no request), GAP (waiting out the inter-access gap), WAKE (chip-select pulse), SETTLE (device start-up wait), START (one-cycle engine start), XFER (engine busy). Transitions: IDLE to GAP on a request. GAP to WAKE or to START when the gap is over, depending on whether a wake is due. WAKE to SETTLE after the pulse length. SETTLE to START after the settle length. START to XFER always. XFER to IDLE on engine done.

Top module: `access_pacer`

## Requirements
- R1: After reset, gnt, spi_start, cs_wake and irq_warn are low, and the first transaction after reset always performs a wake.
- R2: Without an interrupt ending the wait, spi_start for a request that needs no wake comes in the tick interval in which the tick count since the last spi_done reaches the current gap length (FIXED_GAP_TICKS in fixed mode). If the request arrives later, it comes in the interval of the request.
- R3: With irq_present high, a rising edge on ready_irq ends a pending gap in the same tick interval. An edge seen before the request also ends the next gap at once. The pending edge is consumed when spi_start is issued.
- R4: With irq_present low, ready_irq has no effect on pacing, confirmation or irq_warn.
- R5: While unconfirmed, each pre-transaction check counts one attempt. If any interrupt edge has been seen by the time of a check, the gap length becomes IRQ_GAP_TICKS from then on.
- R6: If CONFIRM_TRIES+1 checks pass without any interrupt edge, confirmation stops. The gap stays FIXED_GAP_TICKS even if interrupts are seen later.
- R7: A wake is performed when the tick count since the previous pre-transaction check is at least SLEEP_TICKS. Each check restarts that count.
- R8: A wake drives cs_wake high for WAKE_PULSE_TICKS ticks, then waits WAKE_SETTLE_TICKS ticks before spi_start. cs_wake never rises when no wake is due and is never high while gnt is high.
- R9: A pulse on resume forces a wake before the next transaction.
- R10: irq_warn rises when a gap ends by reaching its length with no pending edge while an interrupt edge has ever been seen. Once high, it stays high until reset.
- R11: spi_start is a one-cycle pulse issued together with the rise of gnt. gnt stays high until spi_done, drops the cycle after it, and only one transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe (nominally 1 ms) |
| irq_present | input | 1 | Ready interrupt line is wired; static outside reset |
| resume | input | 1 | Pulse after a resume from suspend; forces the next wake |
| req | input | 1 | Client requests a transaction |
| gnt | output | 1 | Client owns the device until the engine is done |
| spi_start | output | 1 | One-cycle start to the SPI engine |
| spi_done | input | 1 | Engine reports the transaction finished |
| cs_wake | output | 1 | Chip-select-only wake pulse |
| ready_irq | input | 1 | Ready interrupt from the device, rising-edge active |
| irq_warn | output | 1 | Sticky: proven interrupt missed its ceiling |

## Verification
The bench targets the gap boundary: a request raised before, at, and after the gap end. A design that counts from the request instead of from spi_done, or that is off by one tick, starts an interval early or late. It drives wake distances of exactly one tick below and at the sleep window, which catches a design that compares with the wrong bound or restarts the window at done instead of at the check. It runs confirmation to an edge on the third attempt and also past the attempt limit with a late edge. A design that confirms after the limit would switch to the long ceiling and stretch the gap. It also checks that an unwired interrupt line changes nothing and that the warning is both raised and held.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_GAP,
        PS_WAKE,
        PS_SETTLE,
        PS_START,
        PS_XFER
    } pace_state_t;
endpackage

// File: rtl/pace_tick_counter.sv
// Saturating count of timebase ticks since the last clear.
module pace_tick_counter #(
    parameter int W   = 4,
    parameter int MAX = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_V = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (tick && (count < MAX_V))
            count <= count + W'(1);
    end
endmodule

// File: rtl/pace_irq_confirm.sv
// Ready interrupt edge capture and the bounded confirmation phase.
module pace_irq_confirm #(
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_present,
    input  logic ready_irq,
    input  logic consume,
    input  logic check,
    output logic pending,
    output logic confirmed,
    output logic irq_gap_mode
);
    localparam int AW = $clog2(MAX_TRIES + 2);
    localparam logic [AW-1:0] LIMIT = AW'(MAX_TRIES);

    logic          irq_q;
    logic          rise;
    logic          needs_conf;
    logic [AW-1:0] attempts;
    logic [AW-1:0] attempts_nx;

    assign rise        = irq_present & ready_irq & ~irq_q;
    assign attempts_nx = attempts + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            pending   <= 1'b0;
            confirmed <= 1'b0;
        end else begin
            irq_q     <= ready_irq;
            pending   <= rise | (pending & ~consume);
            confirmed <= confirmed | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            needs_conf   <= 1'b1;
            attempts     <= '0;
            irq_gap_mode <= 1'b0;
        end else if (check && needs_conf) begin
            if (!irq_present) begin
                needs_conf <= 1'b0;
            end else begin
                attempts <= attempts_nx;
                if (confirmed) begin
                    needs_conf   <= 1'b0;
                    irq_gap_mode <= 1'b1;
                end else if (attempts_nx > LIMIT) begin
                    needs_conf <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/access_pacer.sv
module access_pacer
    import pacer_pkg::*;
#(
    parameter int SLEEP_TICKS       = 1000,
    parameter int WAKE_PULSE_TICKS  = 1,
    parameter int WAKE_SETTLE_TICKS = 1,
    parameter int FIXED_GAP_TICKS   = 2,
    parameter int IRQ_GAP_TICKS     = 750,
    parameter int CONFIRM_TRIES     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic irq_present,
    input  logic resume,
    input  logic req,
    output logic gnt,
    output logic spi_start,
    input  logic spi_done,
    output logic cs_wake,
    input  logic ready_irq,
    output logic irq_warn
);
    localparam int GAP_MAX = (FIXED_GAP_TICKS > IRQ_GAP_TICKS) ? FIXED_GAP_TICKS : IRQ_GAP_TICKS;
    localparam int PH_MAX  = (WAKE_PULSE_TICKS > WAKE_SETTLE_TICKS) ? WAKE_PULSE_TICKS : WAKE_SETTLE_TICKS;
    localparam int GW = $clog2(GAP_MAX + 2);
    localparam int SW = $clog2(SLEEP_TICKS + 2);
    localparam int PW = $clog2(PH_MAX + 2);
    localparam logic [GW-1:0] FIX_V    = GW'(FIXED_GAP_TICKS);
    localparam logic [GW-1:0] IRQ_V    = GW'(IRQ_GAP_TICKS);
    localparam logic [SW-1:0] SLEEP_V  = SW'(SLEEP_TICKS);
    localparam logic [PW-1:0] PULSE_V  = PW'(WAKE_PULSE_TICKS);
    localparam logic [PW-1:0] SETTLE_V = PW'(WAKE_SETTLE_TICKS);

    pace_state_t   state, next_state;
    logic [GW-1:0] since_last;
    logic [SW-1:0] since_check;
    logic [PW-1:0] phase;
    logic [GW-1:0] gap_len;
    logic          irq_pending, irq_confirmed, irq_gap_mode;
    logic          force_wake, wake_due, gap_over, check_now;
    logic          enter_start, xfer_end, phase_clr;

    assign gap_len     = irq_gap_mode ? IRQ_V : FIX_V;
    assign gap_over    = irq_pending || (since_last >= gap_len);
    assign check_now   = (state == PS_GAP) && gap_over;
    assign wake_due    = force_wake || (since_check >= SLEEP_V);
    assign xfer_end    = (state == PS_XFER) && spi_done;
    assign enter_start = (next_state == PS_START) && (state != PS_START);
    assign phase_clr   = (next_state != state);

    pace_tick_counter #(.W(GW), .MAX(GAP_MAX)) u_since_last (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(xfer_end), .count(since_last));

    pace_tick_counter #(.W(SW), .MAX(SLEEP_TICKS)) u_since_check (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(check_now), .count(since_check));

    pace_tick_counter #(.W(PW), .MAX(PH_MAX)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(phase_clr), .count(phase));

    pace_irq_confirm #(.MAX_TRIES(CONFIRM_TRIES)) u_confirm (
        .clk(clk), .rst_n(rst_n), .irq_present(irq_present), .ready_irq(ready_irq),
        .consume(enter_start), .check(check_now), .pending(irq_pending),
        .confirmed(irq_confirmed), .irq_gap_mode(irq_gap_mode));

    // State register plus the flags updated at the pre-transaction check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= PS_IDLE;
            force_wake <= 1'b1;
            irq_warn   <= 1'b0;
        end else begin
            state      <= next_state;
            force_wake <= resume | (force_wake & ~check_now);
            if (check_now && !irq_pending && irq_confirmed)
                irq_warn <= 1'b1;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            PS_IDLE:   if (req) next_state = PS_GAP;
            PS_GAP:    if (gap_over) next_state = wake_due ? PS_WAKE : PS_START;
            PS_WAKE:   if (phase >= PULSE_V) next_state = PS_SETTLE;
            PS_SETTLE: if (phase >= SETTLE_V) next_state = PS_START;
            PS_START:  next_state = PS_XFER;
            PS_XFER:   if (spi_done) next_state = PS_IDLE;
            default:   next_state = PS_IDLE;
        endcase
    end

    always_comb begin
        gnt       = (state == PS_START) || (state == PS_XFER);
        spi_start = (state == PS_START);
        cs_wake   = (state == PS_WAKE);
    end
endmodule

// File: rtl/access_pacer_chk.sv
module access_pacer_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_present,
    input logic gnt,
    input logic spi_start,
    input logic spi_done,
    input logic cs_wake,
    input logic irq_warn,
    input logic irq_confirmed
);
    AST_GRANT_OPENS_WITH_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(gnt) |-> spi_start); // R11
    AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) spi_start |=> (gnt && !spi_start)); // R11
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (gnt && !spi_done) |=> gnt); // R11
    AST_GRANT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (gnt && !spi_start && spi_done) |=> !gnt); // R11
    AST_WAKE_OUTSIDE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) cs_wake |-> !gnt); // R8
    AST_SETTLE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_wake) |-> !spi_start); // R8
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) irq_warn |=> irq_warn); // R10
    AST_WARN_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n) irq_warn |-> irq_confirmed); // R10
    AST_NO_EDGE_WITHOUT_LINE: assert property (@(posedge clk) disable iff (!rst_n) !irq_present |-> !irq_confirmed); // R4
endmodule

bind access_pacer access_pacer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_present(irq_present), .gnt(gnt),
    .spi_start(spi_start), .spi_done(spi_done), .cs_wake(cs_wake),
    .irq_warn(irq_warn), .irq_confirmed(irq_confirmed));

// File: tb/sim_access_pacer.sv
module sim_access_pacer;
    localparam int SLEEP = 20, PULSE = 2, SETTLE = 1, FIXG = 3, IRQG = 6, TRIES = 3, TDIV = 16;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, irq_present = 1'b0, resume = 1'b0;
    logic req = 1'b0, spi_done = 1'b0, ready_irq = 1'b0;
    logic gnt, spi_start, cs_wake, irq_warn;

    int vectors = 0, errors = 0, ncyc = 0, tcount = 0;
    bit m_force, m_needs, m_conf, m_use, m_warn;
    int m_att, t_prev, last_done;

    access_pacer #(.SLEEP_TICKS(SLEEP), .WAKE_PULSE_TICKS(PULSE), .WAKE_SETTLE_TICKS(SETTLE),
                   .FIXED_GAP_TICKS(FIXG), .IRQ_GAP_TICKS(IRQG), .CONFIRM_TRIES(TRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .irq_present(irq_present), .resume(resume),
        .req(req), .gnt(gnt), .spi_start(spi_start), .spi_done(spi_done), .cs_wake(cs_wake),
        .ready_irq(ready_irq), .irq_warn(irq_warn));

    always #5 clk = ~clk;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        spi_done = 1'b0; ready_irq = 1'b0; resume = 1'b0;
        ncyc++;
        tick = ((ncyc % TDIV) == 0);
        if (tick) tcount++;
    endtask

    task automatic do_reset(bit present);
        rst_n = 1'b0; irq_present = present; req = 1'b0;
        repeat (3) cyc();
        chk("R1 gnt in reset", int'(gnt), 0);
        chk("R1 start in reset", int'(spi_start), 0);
        chk("R1 cs_wake in reset", int'(cs_wake), 0);
        chk("R1 warn in reset", int'(irq_warn), 0);
        do cyc(); while (tick);
        rst_n = 1'b1;
        m_force = 1; m_needs = 1; m_conf = 0; m_use = 0; m_warn = 0; m_att = 0;
        last_done = tcount; t_prev = tcount;
    endtask

    task automatic do_resume();
        cyc();
        resume = 1'b1;
        m_force = 1;
    endtask

    // r: request tick after last done; i: interrupt tick after last done (0 = none)
    task automatic do_txn(int r, int i, string tag);
        int g, texit, tchk, exp_start, rel, start_rel, wake_ticks, k;
        bit eff, wake, started;
        g = m_use ? IRQG : FIXG;
        if (r < 1) r = 1;
        if (i >= g) i = g - 1;
        if (i < 1) i = 0;
        eff = (i > 0) && irq_present;
        texit = eff ? imax(r, i) : imax(r, g);
        tchk = last_done + texit;
        wake = m_force || ((tchk - t_prev) >= SLEEP);
        m_force = 0; t_prev = tchk;
        if (eff) m_conf = 1;
        if (m_needs) begin
            if (!irq_present) m_needs = 0;
            else begin
                m_att++;
                if (m_conf) begin m_use = 1; m_needs = 0; end
                else if (m_att > TRIES) m_needs = 0;
            end
        end
        if (!eff && m_conf) m_warn = 1;
        exp_start = texit + (wake ? PULSE + SETTLE : 0);

        started = 0; wake_ticks = 0; start_rel = -1;
        while (!started) begin
            cyc();
            rel = tcount - last_done;
            if (cs_wake && tick) wake_ticks++;
            if (spi_start) begin
                started = 1; start_rel = rel;
                chk({tag, " R11 gnt with start"}, int'(gnt), 1);
            end else begin
                if (tick && rel == r) req = 1'b1;
                if (i > 0 && tick && rel == i) ready_irq = 1'b1;
                if (rel > exp_start + 3) begin
                    started = 1;
                end
            end
        end
        req = 1'b0;
        chk({tag, " R2/R3/R5/R7 start tick"}, start_rel, exp_start);
        chk({tag, " R8 wake pulse ticks"}, wake_ticks, wake ? PULSE : 0);
        k = 1 + int'($urandom_range(3));
        repeat (k) begin
            cyc();
            if (!gnt) chk({tag, " R11 gnt held"}, int'(gnt), 1);
            if (spi_start) chk({tag, " R11 start one cycle"}, int'(spi_start), 0);
        end
        cyc();
        spi_done = 1'b1;
        last_done = tcount;
        cyc();
        chk({tag, " R11 gnt drop after done"}, int'(gnt), 0);
        chk({tag, " R10 warn"}, int'(irq_warn), int'(m_warn));
    endtask

    initial begin
        int cycles = 0;
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // Interrupt line absent
        do_reset(1'b0);
        do_txn(1, 0, "R1 first wake");
        do_txn(1, 0, "R2 early request");
        do_txn(2, 1, "R4 edge ignored");
        do_txn(5, 0, "R2 late request");
        do_txn(SLEEP - 1 - (last_done - t_prev), 0, "R7 one below window");
        do_txn(SLEEP - (last_done - t_prev), 0, "R7 at window");
        do_resume();
        do_txn(1, 0, "R9 resume wake");
        for (int n = 0; n < 12; n++)
            do_txn(1 + int'($urandom_range(6)), int'($urandom_range(3)), "R4 random absent");
        do_txn(SLEEP + 3, 0, "R7 long idle");

        // Line present, confirmed on third attempt
        do_reset(1'b1);
        do_txn(1, 0, "R5 attempt 1");
        do_txn(1, 0, "R5 attempt 2");
        do_txn(1, 2, "R5 confirm on 3");
        do_txn(1, 0, "R10 ceiling timeout");
        do_txn(1, 4, "R3 edge ends gap");
        do_txn(5, 2, "R3 edge before request");
        for (int n = 0; n < 16; n++)
            do_txn(1 + int'($urandom_range(8)), int'($urandom_range(5)), "R3 random present");
        do_resume();
        do_txn(2, 0, "R9 resume wake present");

        // Line present, never confirmed within the limit
        do_reset(1'b1);
        for (int n = 0; n < 4; n++) do_txn(1, 0, "R6 no edge");
        do_txn(1, 1, "R6 late edge");
        do_txn(1, 0, "R6 gap stays fixed");
        for (int n = 0; n < 10; n++)
            do_txn(1 + int'($urandom_range(5)), int'($urandom_range(2)), "R6 random");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule